// File: doc/BRIEF.md
# Seconds Time Counter with Alarm

This block keeps a running count of seconds from a slow timer clock. A fixed prescaler divides the timer clock by 8,192 and produces a single-cycle tick, so a nominal 8,192 Hz input advances the count once per second. The count is 32 bits wide and wraps silently. A 32-bit alarm value is compared with the count each time the count steps forward, and a match raises the alarm interrupt source.

Two interrupt sources exist: one fires on every tick and the other fires on an alarm match. Each source has a sticky status flag and its own enable. The block drives one output per source and a combined output. Software uses a small synchronous register port to load the count, program the alarm, set the run and enable bits, and clear the flags. The whole block, including the register port, runs on the timer clock.

Top module: `sca_top`

## Requirements
- R1: The register port decodes `addr` as follows: 0 is the count (read/write), 1 is the alarm (read/write), 2 is control with bit 0 run, bit 1 second-interrupt enable and bit 2 alarm-interrupt enable (other bits read 0), and 3 is status with bit 0 the second flag and bit 1 the alarm flag. Every register and flag resets to zero.
- R2: While run is 1, a tick occurs once every 8,192 clock cycles, and each tick increments the count by exactly one.
- R3: The alarm flag is set on the clock edge where a tick makes the count equal to the alarm value.
- R4: The second flag is set on every tick.
- R5: Flags are sticky. Writing 1 to a status bit clears that flag only, and writing 0 leaves it unchanged. When a set and a clear of the same flag fall in the same cycle, the flag ends up set.
- R6: While run is 0, the count and the prescaler hold their values, and no flag is set.
- R7: Writing the count loads the written value and restarts the prescaler, so the next increment comes exactly 8,192 cycles after the write edge. A count write never sets a flag.
- R8: The count wraps from 0xFFFFFFFF to 0. The wrap raises only the second flag.
- R9: The alarm is evaluated only when a tick increments the count. A count that equals the alarm while it stays constant, or after it is loaded by a write, does not set the alarm flag.
- R10: `irq_sec` is the second flag AND its enable, `irq_alm` is the alarm flag AND its enable, and `irq` is the OR of the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock (nominal 8,192 Hz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| irq_sec | output | 1 | Second interrupt request |
| irq_alm | output | 1 | Alarm interrupt request |
| irq | output | 1 | OR of both requests |

## Verification
A register write takes effect at the first rising edge after the strobe is driven. Read data follows `addr` with no cycle of delay. The count, both flags and the interrupt outputs change on the same edge as a tick, and that tick falls exactly 8,192 edges after the last count write. The bench drives inputs on falling edges and counts falling edges from the one that follows a count write. It samples one edge before the expected tick to confirm the old value, then on the tick edge itself. For the set-wins case it places a status clear so that it is sampled on the tick edge.

// File: rtl/sca_pkg.sv
package sca_pkg;

   typedef enum logic [1:0] {
      REG_COUNT = 2'd0,
      REG_ALARM = 2'd1,
      REG_CTRL  = 2'd2,
      REG_STAT  = 2'd3
   } sca_reg_e;

   localparam int STAT_SEC = 0;
   localparam int STAT_ALM = 1;

   typedef struct packed {
      logic alm_ie;
      logic sec_ie;
      logic run;
   } sca_ctrl_t;

   localparam int CTRL_BITS = $bits(sca_ctrl_t);

endpackage

// File: rtl/sca_prescaler.sv
module sca_prescaler #(
   parameter int DIV = 8192
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);
   localparam int  PW     = (DIV > 1) ? $clog2(DIV) : 1;
   localparam bit  POW2   = ((DIV & (DIV - 1)) == 0);
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   logic [PW-1:0] pre_q;
   logic          at_last;

   assign at_last = (pre_q == LAST);
   assign tick    = run && !restart && at_last;

   generate
      if (POW2) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       pre_q <= '0;
            else if (restart) pre_q <= '0;
            else if (run)     pre_q <= pre_q + 1'b1;
         end
      end else begin : g_mod
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       pre_q <= '0;
            else if (restart) pre_q <= '0;
            else if (run)     pre_q <= at_last ? '0 : pre_q + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/sca_seconds.sv
module sca_seconds #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] alarm,
   output logic [CNT_W-1:0] cnt,
   output logic             hit
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;

   assign cnt_nxt = cnt_q + 1'b1;
   assign hit     = tick && (cnt_nxt == alarm);
   assign cnt     = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (load) cnt_q <= load_val;
      else if (tick) cnt_q <= cnt_nxt;
   end

endmodule

// File: rtl/sca_regs.sv
module sca_regs
   import sca_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              tick,
   input  logic              hit,
   output logic [CNT_W-1:0]  alarm,
   output logic              run,
   output logic              cnt_load,
   output logic              sec_flag,
   output logic              alm_flag,
   output logic              irq_sec,
   output logic              irq_alm,
   output logic [DATA_W-1:0] rd_data
);
   sca_ctrl_t        ctrl_q;
   logic [CNT_W-1:0] alarm_q;
   logic             sec_q, alm_q;
   logic             wr_alarm, wr_ctrl, wr_stat;
   logic             clr_sec, clr_alm;

   assign cnt_load = wr_en && (addr == REG_COUNT);
   assign wr_alarm = wr_en && (addr == REG_ALARM);
   assign wr_ctrl  = wr_en && (addr == REG_CTRL);
   assign wr_stat  = wr_en && (addr == REG_STAT);
   assign clr_sec  = wr_stat && wr_data[STAT_SEC];
   assign clr_alm  = wr_stat && wr_data[STAT_ALM];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         alarm_q <= '0;
      end else begin
         if (wr_ctrl)  ctrl_q  <= sca_ctrl_t'(wr_data[CTRL_BITS-1:0]);
         if (wr_alarm) alarm_q <= wr_data[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q <= 1'b0;
         alm_q <= 1'b0;
      end else begin
         if (tick)         sec_q <= 1'b1;
         else if (clr_sec) sec_q <= 1'b0;
         if (hit)          alm_q <= 1'b1;
         else if (clr_alm) alm_q <= 1'b0;
      end
   end

   always_comb begin
      rd_data = '0;
      case (addr)
         REG_COUNT: rd_data[CNT_W-1:0]     = cnt;
         REG_ALARM: rd_data[CNT_W-1:0]     = alarm_q;
         REG_CTRL:  rd_data[CTRL_BITS-1:0] = ctrl_q;
         default: begin
            rd_data[STAT_SEC] = sec_q;
            rd_data[STAT_ALM] = alm_q;
         end
      endcase
   end

   assign alarm    = alarm_q;
   assign run      = ctrl_q.run;
   assign sec_flag = sec_q;
   assign alm_flag = alm_q;
   assign irq_sec  = sec_q && ctrl_q.sec_ie;
   assign irq_alm  = alm_q && ctrl_q.alm_ie;

endmodule

// File: rtl/sca_top.sv
module sca_top #(
   parameter int DIV    = 8192,
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_sec,
   output logic              irq_alm,
   output logic              irq
);
   generate
      if (DIV < 2) begin : g_bad_div
         $error("sca_top: DIV must be at least 2");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("sca_top: CNT_W must lie in 2..DATA_W");
      end
      if (DATA_W < 3) begin : g_bad_data
         $error("sca_top: DATA_W too narrow for control bits");
      end
   endgenerate

   logic             tick, hit, run, cnt_load;
   logic             sec_flag, alm_flag;
   logic [CNT_W-1:0] cnt, alarm;

   sca_prescaler #(.DIV(DIV)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .restart (cnt_load),
      .tick    (tick)
   );

   sca_seconds #(.CNT_W(CNT_W)) u_sec (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (cnt_load),
      .load_val (wr_data[CNT_W-1:0]),
      .alarm    (alarm),
      .cnt      (cnt),
      .hit      (hit)
   );

   sca_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (addr),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .cnt      (cnt),
      .tick     (tick),
      .hit      (hit),
      .alarm    (alarm),
      .run      (run),
      .cnt_load (cnt_load),
      .sec_flag (sec_flag),
      .alm_flag (alm_flag),
      .irq_sec  (irq_sec),
      .irq_alm  (irq_alm),
      .rd_data  (rd_data)
   );

   assign irq = irq_sec || irq_alm;

endmodule

// File: rtl/sca_checker.sv
module sca_checker #(
   parameter int CNT_W  = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        addr,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic              tick,
   input logic              run,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  alarm,
   input logic              sec_flag,
   input logic              alm_flag,
   input logic              irq_sec,
   input logic              irq_alm,
   input logic              irq
);
   logic cnt_wr, sec_clr, alm_clr;
   assign cnt_wr  = wr_en && (addr == 2'd0);
   assign sec_clr = wr_en && (addr == 2'd3) && wr_data[0];
   assign alm_clr = wr_en && (addr == 2'd3) && wr_data[1];

   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (cnt == $past(cnt) + 1'b1));

   assert_alarm_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (cnt + 1'b1 == alarm)) |=> alm_flag);

   assert_second_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> sec_flag);

   assert_sec_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_flag && !sec_clr) |=> sec_flag);

   assert_alm_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (alm_flag && !alm_clr) |=> alm_flag);

   assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr) |=> $stable(cnt));

   assert_no_tick_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !tick);

   assert_alarm_needs_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alm_flag) |-> $past(tick));

   assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_flag && !alm_flag) |-> !irq);

   assert_irq_combined_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_sec || irq_alm) |-> (irq && (sec_flag || alm_flag)));

endmodule

bind sca_top sca_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr     (addr),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .tick     (tick),
   .run      (run),
   .cnt      (cnt),
   .alarm    (alarm),
   .sec_flag (sec_flag),
   .alm_flag (alm_flag),
   .irq_sec  (irq_sec),
   .irq_alm  (irq_alm),
   .irq      (irq)
);

// File: tb/sca_top_tb.sv
`timescale 1ns/1ps
module sca_top_tb;
   localparam int DIV = 8192;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        irq_sec, irq_alm, irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sca_top u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .irq_sec (irq_sec),
      .irq_alm (irq_alm),
      .irq     (irq)
   );

   // {addr, write value, expected read value}, written while stopped
   localparam logic [65:0] VEC [6] = '{
      {2'd0, 32'h1234_5678, 32'h1234_5678},
      {2'd1, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
      {2'd2, 32'hFFFF_FFF6, 32'h0000_0006},
      {2'd3, 32'hFFFF_FFFF, 32'h0000_0000},
      {2'd0, 32'h0000_0000, 32'h0000_0000},
      {2'd1, 32'h0000_0000, 32'h0000_0000}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // called at a falling edge; write is sampled at the next rising edge
   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      addr = a;
      #0.1;
      d = rd_data;
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);

      // reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         check("R1 reset value", v, 32'h0);
      end
      check("R10 reset irq", {29'd0, irq_sec, irq_alm, irq}, 32'h0);

      // table walk
      for (int i = 0; i < 6; i++) begin
         wr(VEC[i][65:64], VEC[i][63:32]);
         rd(VEC[i][65:64], v);
         check("R1 register readback", v, VEC[i][31:0]);
      end

      // tick period, second and alarm
      wr(2'd2, 32'h7);
      wr(2'd1, 32'd102);
      wr(2'd0, 32'd100);
      wait_n(DIV - 1);
      rd(2'd0, v); check("R7 no tick before full period", v, 32'd100);
      rd(2'd3, v); check("R7 load sets no flag", v, 32'h0);
      wait_n(1);
      rd(2'd0, v); check("R2 increment on tick", v, 32'd101);
      rd(2'd3, v); check("R4 second flag set", v, 32'h1);
      check("R10 irq_sec and irq", {30'd0, irq_sec, irq}, 32'h3);
      wr(2'd3, 32'h1);
      rd(2'd3, v); check("R5 write one clears", v, 32'h0);
      wait_n(DIV - 1);
      rd(2'd0, v); check("R2 second tick", v, 32'd102);
      rd(2'd3, v); check("R3 alarm flag on match", v, 32'h3);
      check("R10 irq_alm", {31'd0, irq_alm}, 32'h1);
      wr(2'd3, 32'h2);
      rd(2'd3, v); check("R5 clear only alarm", v, 32'h1);
      wr(2'd3, 32'h0);
      rd(2'd3, v); check("R5 write zero keeps flag", v, 32'h1);
      wr(2'd3, 32'h1);

      // stopped
      wr(2'd2, 32'h6);
      wait_n(DIV + 900);
      rd(2'd0, v); check("R6 count held while stopped", v, 32'd102);
      rd(2'd3, v); check("R6 no flag while stopped", v, 32'h0);

      // set wins over clear
      wr(2'd2, 32'h7);
      wr(2'd0, 32'd200);
      wait_n(DIV - 1);
      wr(2'd3, 32'h1);
      rd(2'd0, v); check("R2 count at set-wins tick", v, 32'd201);
      rd(2'd3, v); check("R5 set wins over clear", v, 32'h1);
      wr(2'd3, 32'h1);

      // wrap
      wr(2'd1, 32'd5);
      wr(2'd0, 32'hFFFF_FFFF);
      wait_n(DIV);
      rd(2'd0, v); check("R8 wrap to zero", v, 32'h0);
      rd(2'd3, v); check("R8 wrap raises only second", v, 32'h1);
      wr(2'd3, 32'h3);

      // enable gating
      wr(2'd2, 32'h5);
      wr(2'd0, 32'd10);
      wait_n(DIV);
      rd(2'd3, v); check("R4 flag with enable off", v, 32'h1);
      check("R10 masked irq", {30'd0, irq_sec, irq}, 32'h0);
      wr(2'd3, 32'h1);

      // constant count equal to alarm
      wr(2'd2, 32'h6);
      wr(2'd1, 32'd11);
      wait_n(50);
      rd(2'd3, v); check("R9 constant equal count no alarm", v, 32'h0);
      wr(2'd0, 32'd11);
      wait_n(5);
      rd(2'd3, v); check("R9 load equal to alarm no alarm", v, 32'h0);
      check("R9 irq_alm idle", {31'd0, irq_alm}, 32'h0);

      finish_run();
   end
endmodule